// File: doc/BRIEF.md
# Single/Dual Issue Sequencer

This block decides, every cycle, whether the fetch stage hands out one 32-bit instruction or a 64-bit pair. In single-issue mode the word at the current fetch address is picked out of the 64-bit fetch block. It is routed to either the core output or the floating-point output, depending on its class. In dual-issue mode the whole block is issued at once: the low half goes to the floating-point unit and the high half goes to the integer core.

The change between the two modes is deliberately late. A floating-point instruction with its dual flag set, seen in single mode, lets exactly one more instruction go out singly, and only then do pairs start. A floating-point instruction in the low slot of a pair with the dual flag clear lets one more pair go out before single issue resumes. A lone pair can therefore be bracketed into a short dual episode. Pairs must start on an 8-byte boundary, so an entry that lands mid-block keeps issuing singly until the address is aligned. A redirect reloads the fetch address, drops any pending entry or exit, and returns to single mode.

Top module: `dis_issue_seq`

## Requirements
- R1: After reset the fetch address equals the RESET_ADDR parameter (0 by default), the mode is single, and no valid output is raised while fetch_valid is low.
- R2: In single mode one instruction issues per accepted cycle. It is the low 32 bits of fetch_word when fetch_addr[2] is 0 and the high 32 bits when it is 1. It goes out on the floating-point output if it is of floating-point class, otherwise on the core output; fetch_addr then advances by 4.
- R3: An instruction is of floating-point class when its bits [31:26] equal 6'b010010, and its dual flag is bit 9; any other value of bits [31:26] is a core instruction, whatever bit 9 holds.
- R4: A floating-point instruction with the dual flag set, issued in single mode, is followed by exactly one more single issue before pair issue begins.
- R5: In dual mode each accepted cycle raises both valids, with fetch_word[31:0] on the floating-point output and fetch_word[63:32] on the core output, and fetch_addr advances by 8; a pair is only ever issued from an 8-byte-aligned address.
- R6: A floating-point-class low slot with the dual flag clear, issued in dual mode, is followed by exactly one more pair, after which single mode resumes.
- R7: When the one extra single issue of an entry leaves fetch_addr not 8-byte aligned, single issue continues until the address is aligned, and then pair issue begins.
- R8: While stall is high or fetch_valid is low, no valid output is raised and both the fetch address and the mode hold.
- R9: A redirect loads redirect_addr into fetch_addr on the next edge, cancels any pending entry or exit, selects single mode, and issues nothing in its own cycle; it takes priority over stall.
- R10: A core-class word in the low slot keeps dual mode going, and the dual flag of the extra single issue during entry and of the extra pair during exit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fetch_word | input | 64 | 8-byte fetch block containing fetch_addr |
| fetch_valid | input | 1 | fetch_word is valid this cycle |
| stall | input | 1 | Downstream cannot accept an issue |
| redirect | input | 1 | Load a new fetch address |
| redirect_addr | input | 32 | Target address for redirect |
| fetch_addr | output | 32 | Current fetch pointer |
| core_instr | output | 32 | Instruction for the integer core |
| core_valid | output | 1 | core_instr is issued this cycle |
| fp_instr | output | 32 | Instruction for the floating-point unit |
| fp_valid | output | 1 | fp_instr is issued this cycle |

## Verification
The hardest situation to reach is an entry that ends mid-block. It needs a flagged floating-point instruction in the high half of a block, followed by an extra single issue at an aligned address, so that the sequencer must keep issuing singly for one more word before pairing. The stimulus gets there by redirecting to an odd word address and placing the flagged instruction at the next high slot. The same path first checks that a redirect issued right after a flagged instruction really cancels the entry: a word at an aligned address is then shown to issue alone rather than as a pair.

// File: rtl/dis_pkg.sv
package dis_pkg;
    typedef enum logic [1:0] {
        ST_SINGLE = 2'd0,
        ST_ENTER  = 2'd1,
        ST_DUAL   = 2'd2,
        ST_EXIT   = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dis_fp_decode.sv
module dis_fp_decode #(
    parameter int        INSTR_W  = 32,
    parameter int        OPC_W    = 6,
    parameter logic [5:0] FP_OPC  = 6'b010010,
    parameter int        DBIT_POS = 9
) (
    input  logic [INSTR_W-1:0] instr,
    output logic               is_fp,
    output logic               dual_flag
);
    localparam int OPC_LSB = INSTR_W - OPC_W;

    always_comb begin
        is_fp     = (instr[INSTR_W-1:OPC_LSB] == FP_OPC[OPC_W-1:0]);
        dual_flag = instr[DBIT_POS];
    end
endmodule

// File: rtl/dis_slot_steer.sv
module dis_slot_steer #(
    parameter int INSTR_W = 32
) (
    input  logic [2*INSTR_W-1:0] block,
    input  logic                 hi_word,
    output logic [INSTR_W-1:0]   slot_lo,
    output logic [INSTR_W-1:0]   slot_hi,
    output logic [INSTR_W-1:0]   slot_sel
);
    always_comb begin
        slot_lo  = block[INSTR_W-1:0];
        slot_hi  = block[2*INSTR_W-1:INSTR_W];
        slot_sel = hi_word ? slot_hi : slot_lo;
    end
endmodule

// File: rtl/dis_issue_seq.sv
module dis_issue_seq #(
    parameter int               ADDR_W     = 32,
    parameter int               INSTR_W    = 32,
    parameter int               DBIT_POS   = 9,
    parameter logic [5:0]       FP_OPC     = 6'b010010,
    parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2*INSTR_W-1:0] fetch_word,
    input  logic                 fetch_valid,
    input  logic                 stall,
    input  logic                 redirect,
    input  logic [ADDR_W-1:0]    redirect_addr,
    output logic [ADDR_W-1:0]    fetch_addr,
    output logic [INSTR_W-1:0]   core_instr,
    output logic                 core_valid,
    output logic [INSTR_W-1:0]   fp_instr,
    output logic                 fp_valid
);
    import dis_pkg::*;

    localparam int              WORD_BYTES = INSTR_W / 8;
    localparam int              HI_BIT     = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP1    = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP2    = ADDR_W'(2 * WORD_BYTES);

    typedef struct packed {
        seq_state_e        state;
        logic [ADDR_W-1:0] addr;
    } seq_regs_t;

    seq_regs_t r_q, r_d;

    logic [INSTR_W-1:0] slot_lo, slot_hi, slot_sel;
    logic sel_fp, sel_dflag, lo_fp, lo_dflag;
    logic issue_en, pair_state, pair_issue, single_issue;
    logic [ADDR_W-1:0] addr_plus1;

    dis_slot_steer #(.INSTR_W(INSTR_W)) u_steer (
        .block    (fetch_word),
        .hi_word  (r_q.addr[HI_BIT]),
        .slot_lo  (slot_lo),
        .slot_hi  (slot_hi),
        .slot_sel (slot_sel)
    );

    dis_fp_decode #(.INSTR_W(INSTR_W), .FP_OPC(FP_OPC), .DBIT_POS(DBIT_POS)) u_dec_sel (
        .instr     (slot_sel),
        .is_fp     (sel_fp),
        .dual_flag (sel_dflag)
    );

    dis_fp_decode #(.INSTR_W(INSTR_W), .FP_OPC(FP_OPC), .DBIT_POS(DBIT_POS)) u_dec_lo (
        .instr     (slot_lo),
        .is_fp     (lo_fp),
        .dual_flag (lo_dflag)
    );

    always_comb begin
        issue_en     = fetch_valid && !stall && !redirect;
        pair_state   = (r_q.state == ST_DUAL) || (r_q.state == ST_EXIT);
        pair_issue   = issue_en && pair_state;
        single_issue = issue_en && !pair_state;
        addr_plus1   = r_q.addr + STEP1;

        core_valid = pair_issue || (single_issue && !sel_fp);
        fp_valid   = pair_issue || (single_issue && sel_fp);
        core_instr = pair_state ? slot_hi : slot_sel;
        fp_instr   = pair_state ? slot_lo : slot_sel;
        fetch_addr = r_q.addr;

        r_d = r_q;
        if (redirect) begin
            r_d.addr  = redirect_addr;
            r_d.state = ST_SINGLE;
        end else if (issue_en) begin
            unique case (r_q.state)
                ST_SINGLE: begin
                    r_d.addr = addr_plus1;
                    if (sel_fp && sel_dflag) r_d.state = ST_ENTER;
                end
                ST_ENTER: begin
                    r_d.addr = addr_plus1;
                    if (addr_plus1[HI_BIT:0] == '0) r_d.state = ST_DUAL;
                end
                ST_DUAL: begin
                    r_d.addr = r_q.addr + STEP2;
                    if (lo_fp && !lo_dflag) r_d.state = ST_EXIT;
                end
                ST_EXIT: begin
                    r_d.addr  = r_q.addr + STEP2;
                    r_d.state = ST_SINGLE;
                end
                default: r_d.state = ST_SINGLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= ST_SINGLE;
            r_q.addr  <= RESET_ADDR;
        end else begin
            r_q <= r_d;
        end
    end

    // Pair issue only from an aligned block (R5)
    p_pair_aligned_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && fp_valid) |-> (fetch_addr[HI_BIT:0] == '0));

    // Pair advances by a full block (R5)
    p_pair_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid && fp_valid) |=> (fetch_addr == $past(fetch_addr) + STEP2));

    // Lone issue advances by one word (R2)
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (core_valid != fp_valid) |=> (fetch_addr == $past(fetch_addr) + STEP1));

    // Idle cycles hold pointer and mode (R8)
    p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && !core_valid && !fp_valid) |=> ($stable(fetch_addr) && $stable(r_q.state)));

    // Redirect reloads and returns to single (R9)
    p_redirect_r9: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (fetch_addr == $past(redirect_addr)) && (r_q.state == ST_SINGLE));

    // Flagged single FP op arms the delayed entry (R4)
    p_enter_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_SINGLE && fp_valid && !core_valid && sel_dflag) |=> (r_q.state == ST_ENTER));

    // The trailing pair always returns to single (R6)
    p_exit_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_EXIT && core_valid) |=> (r_q.state == ST_SINGLE));
endmodule

// File: tb/dis_issue_seq_tb.sv
module dis_issue_seq_tb;
    localparam logic [31:0] FPD1 = 32'h4800_0200;
    localparam logic [31:0] FP0  = 32'h4800_0000;

    typedef struct packed {
        logic        stall;
        logic        fv;
        logic        redir;
        logic [31:0] raddr;
        logic [63:0] word;
        logic        ecv;
        logic        efv;
        logic [31:0] ecore;
        logic [31:0] efp;
        logic [31:0] eaddr;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{0,0,0,0,64'h0,                            0,0,0,0,32'h000,1},   // R1 idle after reset
        '{0,1,0,0,{32'h10000001,32'h10000000},      1,0,32'h10000000,0,32'h000,2}, // R2 low word
        '{0,1,0,0,{32'h10000001,32'h10000000},      1,0,32'h10000001,0,32'h004,2}, // R2 high word
        '{0,1,0,0,{32'h10000003,FPD1},              0,1,0,FPD1,32'h008,3},         // R3 fp class, flag set
        '{0,1,0,0,{32'h10000003,FPD1},              1,0,32'h10000003,0,32'h00C,4}, // R4 one more single
        '{0,1,0,0,{32'h10000005,32'h10000004},      1,1,32'h10000005,32'h10000004,32'h010,10}, // R10 core low slot
        '{0,1,0,0,{32'h10000007,FP0},               1,1,32'h10000007,FP0,32'h018,5},  // R5 pair, exit armed
        '{0,1,0,0,{32'h10000009,FPD1},              1,1,32'h10000009,FPD1,32'h020,6}, // R6 one more pair
        '{0,1,0,0,{32'h1000000B,32'h1000000A},      1,0,32'h1000000A,0,32'h028,6},    // R6 back to single
        '{1,1,0,0,{32'h1000000B,32'h1000000A},      0,0,0,0,32'h02C,8},   // R8 stall
        '{0,0,0,0,{32'h1000000B,32'h1000000A},      0,0,0,0,32'h02C,8},   // R8 no fetch
        '{0,1,0,0,{FPD1,32'h1000000A},              0,1,0,FPD1,32'h02C,4},// R4 arm entry
        '{0,1,1,32'h104,{32'h1000000D,32'h1000000C},0,0,0,0,32'h030,9},   // R9 redirect
        '{0,1,0,0,{32'h10000013,32'h10000012},      1,0,32'h10000013,0,32'h104,9}, // R9 target
        '{0,1,0,0,{32'h10000015,FP0},               0,1,0,FP0,32'h108,9},  // R9 entry cancelled
        '{0,1,0,0,{FPD1,32'h10000016},              0,1,0,FPD1,32'h10C,7}, // R7 arm mid-block
        '{0,1,0,0,{32'h10000017,FP0},               0,1,0,FP0,32'h110,10}, // R10 flag ignored in entry
        '{0,1,0,0,{32'h10000019,32'h10000018},      1,0,32'h10000019,0,32'h114,7}, // R7 extra single
        '{0,1,0,0,{32'h1000001B,FP0},               1,1,32'h1000001B,FP0,32'h118,7}, // R7 pair aligned
        '{1,1,0,0,{32'h1000001B,FP0},               0,0,0,0,32'h120,8},    // R8 stall in exit
        '{0,1,0,0,{32'h1000001D,FPD1},              1,1,32'h1000001D,FPD1,32'h120,10}, // R10 flag ignored in exit
        '{0,1,0,0,{32'h1000001F,32'h1000001E},      1,0,32'h1000001E,0,32'h128,6},
        '{1,1,1,32'h200,{32'h1000001F,32'h1000001E},0,0,0,0,32'h12C,9},    // R9 beats stall
        '{0,1,0,0,{32'h10000021,32'h10000020},      1,0,32'h10000020,0,32'h200,9}
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic [63:0] fetch_word;
    logic        fetch_valid, stall, redirect;
    logic [31:0] redirect_addr, fetch_addr, core_instr, fp_instr;
    logic        core_valid, fp_valid;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    dis_issue_seq u_dut (
        .clk(clk), .rst_n(rst_n), .fetch_word(fetch_word), .fetch_valid(fetch_valid),
        .stall(stall), .redirect(redirect), .redirect_addr(redirect_addr),
        .fetch_addr(fetch_addr), .core_instr(core_instr), .core_valid(core_valid),
        .fp_instr(fp_instr), .fp_valid(fp_valid)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic fv, input logic rd, input logic [31:0] ra, input logic [63:0] w);
        stall = s; fetch_valid = fv; redirect = rd; redirect_addr = ra; fetch_word = w;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        drive(0, 0, 0, 0, 64'h0);
        #1;
        chk("R1", "reset addr", fetch_addr, 32'h0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string rq;
            @(negedge clk);
            drive(VECS[i].stall, VECS[i].fv, VECS[i].redir, VECS[i].raddr, VECS[i].word);
            #1;
            rq = $sformatf("R%0d vec%0d", VECS[i].req, i);
            chk(rq, "fetch_addr", fetch_addr, VECS[i].eaddr);
            chk(rq, "core_valid", {31'b0, core_valid}, {31'b0, VECS[i].ecv});
            chk(rq, "fp_valid", {31'b0, fp_valid}, {31'b0, VECS[i].efv});
            if (VECS[i].ecv) chk(rq, "core_instr", core_instr, VECS[i].ecore);
            if (VECS[i].efv) chk(rq, "fp_instr", fp_instr, VECS[i].efp);
        end

        // R1: reset in the middle of a run
        @(negedge clk);
        drive(0, 0, 0, 0, 64'h0);
        rst_n = 1'b0;
        #1;
        chk("R1", "addr in reset", fetch_addr, 32'h0);
        chk("R1", "no issue", {30'b0, core_valid, fp_valid}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: matching opcode field means floating-point class
        @(negedge clk);
        drive(0, 1, 0, 0, {32'h10000000, FP0});
        #1;
        chk("R3", "fp class valid", {30'b0, core_valid, fp_valid}, 32'h1);
        // R3: other opcode with bit 9 set is a core instruction
        @(negedge clk);
        drive(0, 1, 0, 0, {32'h4C000200, FP0});
        #1;
        chk("R3", "core class valid", {30'b0, core_valid, fp_valid}, 32'h2);
        chk("R3", "core word", core_instr, 32'h4C000200);
        @(negedge clk);
        drive(0, 1, 0, 0, {32'h10000001, 32'h10000000});
        #1;
        chk("R3", "no dual entry", {30'b0, core_valid, fp_valid}, 32'h2);
        chk("R2", "addr after two", fetch_addr, 32'h8);

        @(negedge clk);
        drive(0, 0, 0, 0, 64'h0);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule